// File: doc/BRIEF.md
# Serial Request Decoder

This block sits on the physical-layer side of a PHY-to-link connection. It receives the link's one-wire serial request line and samples it once per system clock. The line rests low. A frame opens with a 1 and closes with a 0, and the bits in between arrive most significant first, one per clock. A 3-bit kind field follows the opening bit and fixes how long the frame is. The kind selects one of three actions: a bus request that carries an arbitration kind and a speed code, a register read whose address goes to the status sender, or a register write that lands in a small local register file.

Decoded bus requests and read addresses leave through two valid/ready output channels. The serial line cannot be stalled, so neither channel applies back-pressure to the input. A channel holds its payload until `ready` is seen high at a rising edge. If a new result of the same channel completes while the old one is still pending, the newer one replaces it. The register file holds two sticky interrupt bits whose causes are hardware inputs. It also holds a self-clearing trigger that starts a short arbitrated bus reset. A frame with a bad closing bit or a reserved kind raises a one-cycle error pulse and is otherwise discarded.

Top module: `serial_req_decoder`

## Requirements
- R1: After reset, `breq_valid`, `rd_valid`, `srst_pulse` and `frm_err` are 0, and every register reads 0x00.
- R2: A 1 sampled on `req_line` while idle starts a frame. The bits that follow are taken MSB first, one per clock. A result appears in the second cycle after the edge that samples the closing bit (error pulse: first cycle).
- R3: A 7-bit frame (1, kind 000/001/010/011, 2-bit speed, 0) sets `breq_valid` with `breq_kind` equal to the kind and `breq_speed` equal to the speed field (00 = 100 Mb/s, 01 = 200 Mb/s).
- R4: A 9-bit frame (1, 100, 4-bit address, 0) sets `rd_valid` with `rd_addr` equal to the address. `rd_data` shows the current contents of that register.
- R5: A 17-bit frame (1, 101, 4-bit address, 8-bit data, 0) writes the data to the addressed register on the edge after the frame completes.
- R6: A request of kind 010 or 011 is dropped without error if `rx_busy` is high on any sampled bit of its frame. Kinds 000 and 001 are not affected by `rx_busy`.
- R7: Register 6 bit 1 (power) and bit 0 (loop) are set on every edge at which `cable_pwr_low` or `loop_timeout` respectively is high. Writing 0 clears a bit, but setting wins while its cause is high. Writing 1 leaves the bit unchanged.
- R8: A write to register 9 with data bit 7 set pulses `srst_pulse` for one cycle only when `short_mode` is 1. Register 9 bit 7 always reads 0, and its other bits store normally.
- R9: A frame whose closing bit is 1, or whose kind is 110 or 111, raises `frm_err` for one cycle and changes no register and no output channel. A reserved kind frame is 7 bits long.
- R10: A new opening bit is accepted on the clock right after a closing bit.
- R11: A channel holds `valid` and its payload until `ready` is high at a rising edge. A newer result of the same channel overwrites a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_line | input | 1 | Serial request line from the link |
| rx_busy | input | 1 | PHY is in its receive state |
| cable_pwr_low | input | 1 | Cause of the power interrupt bit |
| loop_timeout | input | 1 | Cause of the loop interrupt bit |
| short_mode | input | 1 | Enables short arbitrated reset |
| breq_valid | output | 1 | Bus request pending |
| breq_ready | input | 1 | Bus request accepted |
| breq_kind | output | 3 | Arbitration kind of the request |
| breq_speed | output | 2 | Speed code of the request |
| rd_valid | output | 1 | Read address pending |
| rd_ready | input | 1 | Read address accepted |
| rd_addr | output | AW | Register address to report |
| rd_data | output | DW | Live contents of `rd_addr` |
| srst_pulse | output | 1 | Start a short arbitrated bus reset |
| frm_err | output | 1 | Malformed frame discarded |

## Verification
The bench builds the block with its defaults, AW = 4 and DW = 8. That gives 16 eight-bit registers, so random writes and reads reach every address, including the interrupt register 6 and the reset-trigger register 9. With these widths a write frame is 17 bits long, so the bench mixes 7-, 9- and 17-bit frames back to back with malformed ones. This drives the length selection and the overwrite rule of both output channels.

// File: rtl/serial_req_pkg.sv
package serial_req_pkg;
  typedef enum logic [2:0] {
    K_IMM   = 3'b000,
    K_ISO   = 3'b001,
    K_PRI   = 3'b010,
    K_FAIR  = 3'b011,
    K_READ  = 3'b100,
    K_WRITE = 3'b101,
    K_RSV6  = 3'b110,
    K_RSV7  = 3'b111
  } req_kind_e;

  localparam int KIND_W  = 3;
  localparam int SPEED_W = 2;
endpackage

// File: rtl/serial_req_deframer.sv
module serial_req_deframer
  import serial_req_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  logic                 rx_busy_i,
  output logic                 done_o,
  output req_kind_e            kind_o,
  output logic [3+AW+DW:0]     word_o,
  output logic                 rx_seen_o
);
  localparam int BUS_LEN = KIND_W + SPEED_W + 1;
  localparam int RD_LEN  = KIND_W + AW + 1;
  localparam int WR_LEN  = KIND_W + AW + DW + 1;
  localparam int CW      = $clog2(WR_LEN + 1);

  logic            busy_q, rxs_q;
  logic [CW-1:0]   cnt_q, cnt_nx, need;
  logic [WR_LEN-1:0] sr_q, sr_nx;
  req_kind_e       kind_q;

  assign cnt_nx = cnt_q + 1'b1;
  assign sr_nx  = {sr_q[WR_LEN-2:0], line_i};

  always_comb begin
    if (cnt_q < CW'(KIND_W)) need = CW'(WR_LEN);
    else begin
      unique case (kind_q)
        K_READ:  need = CW'(RD_LEN);
        K_WRITE: need = CW'(WR_LEN);
        default: need = CW'(BUS_LEN);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rxs_q     <= 1'b0;
      cnt_q     <= '0;
      sr_q      <= '0;
      kind_q    <= K_IMM;
      done_o    <= 1'b0;
      kind_o    <= K_IMM;
      word_o    <= '0;
      rx_seen_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (line_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          sr_q   <= '0;
          rxs_q  <= rx_busy_i;
        end
      end else begin
        sr_q  <= sr_nx;
        rxs_q <= rxs_q | rx_busy_i;
        if (cnt_q == CW'(KIND_W - 1)) kind_q <= req_kind_e'({sr_q[1:0], line_i});
        if (cnt_nx == need) begin
          busy_q    <= 1'b0;
          done_o    <= 1'b1;
          kind_o    <= kind_q;
          word_o    <= sr_nx;
          rx_seen_o <= rxs_q | rx_busy_i;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/serial_req_regfile.sv
module serial_req_regfile #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int INT_ADDR  = 6,
  parameter int PWR_BIT   = 1,
  parameter int LOOP_BIT  = 0,
  parameter int SRST_ADDR = 9,
  parameter int SRST_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          pwr_cause_i,
  input  logic          loop_cause_i,
  input  logic          short_mode_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    int_bits_o,
  output logic          srst_pulse_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] rows [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q, nxt;
    logic          hit;
    assign hit = we_i && (waddr_i == AW'(i));

    always_comb begin
      nxt = q;
      if (hit) nxt = wdata_i;
      if (i == INT_ADDR) begin
        nxt[PWR_BIT]  = pwr_cause_i  | (q[PWR_BIT]  & (!hit | wdata_i[PWR_BIT]));
        nxt[LOOP_BIT] = loop_cause_i | (q[LOOP_BIT] & (!hit | wdata_i[LOOP_BIT]));
      end
      if (i == SRST_ADDR) nxt[SRST_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign rows[i] = q;
  end

  assign rdata_o      = rows[raddr_i];
  assign int_bits_o   = {rows[INT_ADDR][PWR_BIT], rows[INT_ADDR][LOOP_BIT]};
  assign srst_pulse_o = we_i && (waddr_i == AW'(SRST_ADDR)) &&
                        wdata_i[SRST_BIT] && short_mode_i;
endmodule

// File: rtl/serial_req_decoder.sv
module serial_req_decoder
  import serial_req_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_line,
  input  logic          rx_busy,
  input  logic          cable_pwr_low,
  input  logic          loop_timeout,
  input  logic          short_mode,
  output logic          breq_valid,
  input  logic          breq_ready,
  output logic [2:0]    breq_kind,
  output logic [1:0]    breq_speed,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          srst_pulse,
  output logic          frm_err
);
  localparam int WR_LEN = KIND_W + AW + DW + 1;

  logic              done, rx_seen, bad, fire, drop, is_bus;
  req_kind_e         kind;
  logic [WR_LEN-1:0] word;
  logic [1:0]        int_bits;

  serial_req_deframer #(.AW(AW), .DW(DW)) u_deframer (
    .clk(clk), .rst_n(rst_n), .line_i(req_line), .rx_busy_i(rx_busy),
    .done_o(done), .kind_o(kind), .word_o(word), .rx_seen_o(rx_seen)
  );

  assign bad    = word[0] || (kind == K_RSV6) || (kind == K_RSV7);
  assign fire   = done && !bad;
  assign is_bus = (kind == K_IMM) || (kind == K_ISO) || (kind == K_PRI) || (kind == K_FAIR);
  assign drop   = rx_seen && ((kind == K_PRI) || (kind == K_FAIR));
  assign frm_err = done && bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      breq_valid <= 1'b0;
      breq_kind  <= '0;
      breq_speed <= '0;
      rd_valid   <= 1'b0;
      rd_addr    <= '0;
    end else begin
      if (fire && is_bus && !drop) begin
        breq_valid <= 1'b1;
        breq_kind  <= kind;
        breq_speed <= word[SPEED_W:1];
      end else if (breq_ready) begin
        breq_valid <= 1'b0;
      end
      if (fire && kind == K_READ) begin
        rd_valid <= 1'b1;
        rd_addr  <= word[AW:1];
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  serial_req_regfile #(.AW(AW), .DW(DW)) u_regfile (
    .clk(clk), .rst_n(rst_n),
    .we_i(fire && kind == K_WRITE),
    .waddr_i(word[AW+DW:DW+1]),
    .wdata_i(word[DW:1]),
    .raddr_i(rd_addr),
    .pwr_cause_i(cable_pwr_low),
    .loop_cause_i(loop_timeout),
    .short_mode_i(short_mode),
    .rdata_o(rd_data),
    .int_bits_o(int_bits),
    .srst_pulse_o(srst_pulse)
  );
endmodule

// File: rtl/serial_req_decoder_chk.sv
module serial_req_decoder_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cable_pwr_low,
  input logic          loop_timeout,
  input logic          short_mode,
  input logic          breq_valid,
  input logic          breq_ready,
  input logic [2:0]    breq_kind,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          srst_pulse,
  input logic          frm_err,
  input logic [1:0]    int_bits
);
  p_breq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid && !breq_ready |=> breq_valid);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid);
  p_pwr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cable_pwr_low |=> int_bits[1]);
  p_loop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_timeout |=> int_bits[0]);
  p_srst_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |-> short_mode);
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> !srst_pulse ##1 !$rose(rd_valid) && !$rose(breq_valid));
  p_breq_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid |-> !breq_kind[2]);
endmodule

bind serial_req_decoder serial_req_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cable_pwr_low(cable_pwr_low),
  .loop_timeout(loop_timeout), .short_mode(short_mode),
  .breq_valid(breq_valid), .breq_ready(breq_ready), .breq_kind(breq_kind),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .srst_pulse(srst_pulse), .frm_err(frm_err), .int_bits(int_bits)
);

// File: tb/serial_req_decoder_bench.sv
`timescale 1ns/1ps
module serial_req_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_line = 0, rx_busy = 0, cable_pwr_low = 0, loop_timeout = 0, short_mode = 0;
  logic breq_ready = 0, rd_ready = 0;
  logic breq_valid, rd_valid, srst_pulse, frm_err;
  logic [2:0] breq_kind;
  logic [1:0] breq_speed;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, err_seen = 0, srst_seen = 0, exp_err = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  serial_req_decoder u_serial_req_decoder (.*);

  always @(posedge clk) begin
    if (frm_err) err_seen++;
    if (srst_pulse) srst_seen++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] f, int len, int rx_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      req_line = f[len-1-i];
      rx_busy  = (i == rx_at);
    end
  endtask

  task automatic settle();
    @(negedge clk); req_line = 0; rx_busy = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] f_bus(logic [2:0] k, logic [1:0] s);
    return {25'd0, 1'b1, k, s, 1'b0};
  endfunction
  function automatic logic [31:0] f_rd(logic [3:0] a);
    return {23'd0, 1'b1, 3'b100, a, 1'b0};
  endfunction
  function automatic logic [31:0] f_wr(logic [3:0] a, logic [7:0] d, logic stp);
    return {15'd0, 1'b1, 3'b101, a, d, stp};
  endfunction

  function automatic void model_write(logic [3:0] a, logic [7:0] d);
    if (a == 4'd6) model[6] = {d[7:2], model[6][1:0] & d[1:0]};
    else if (a == 4'd9) model[9] = {1'b0, d[6:0]};
    else model[a] = d;
  endfunction

  task automatic take_breq();
    breq_ready = 1; @(negedge clk); breq_ready = 0;
  endtask
  task automatic take_rd();
    rd_ready = 1; @(negedge clk); rd_ready = 0;
  endtask

  task automatic read_check(string req, logic [3:0] a);
    send(f_rd(a), 9, -1); settle();
    check({req, " rd_valid"}, rd_valid, 1);
    check({req, " rd_addr"}, rd_addr, a);
    check({req, " rd_data"}, rd_data, model[a]);
    take_rd();
    check({req, " rd drop"}, rd_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    void'($urandom(32'h5eed1394));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 breq_valid", breq_valid, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 srst", srst_pulse, 0);
    check("R1 err", frm_err, 0);
    read_check("R1", 4'd3);

    // R2 R3 timing and bus request fields
    send(f_bus(3'b001, 2'b01), 7, -1);
    @(negedge clk); req_line = 0;
    check("R2 not yet valid", breq_valid, 0);
    @(negedge clk);
    check("R2 valid after two edges", breq_valid, 1);
    check("R3 kind", breq_kind, 3'b001);
    check("R3 speed", breq_speed, 2'b01);
    take_breq();
    check("R11 consumed", breq_valid, 0);

    // R6 receive state drops fair/priority only
    send(f_bus(3'b011, 2'b00), 7, 3); settle();
    check("R6 fair dropped", breq_valid, 0);
    send(f_bus(3'b010, 2'b01), 7, 0); settle();
    check("R6 priority dropped", breq_valid, 0);
    send(f_bus(3'b000, 2'b01), 7, 6); settle();
    check("R6 immediate kept", breq_valid, 1);
    check("R6 immediate kind", breq_kind, 3'b000);
    take_breq();

    // R11 overwrite while pending
    send(f_bus(3'b001, 2'b00), 7, -1);
    send(f_bus(3'b011, 2'b01), 7, -1); settle();
    check("R11 valid held", breq_valid, 1);
    check("R11 newest kind", breq_kind, 3'b011);
    check("R11 newest speed", breq_speed, 2'b01);
    take_breq();

    // R5 R10 back-to-back write then read
    send(f_wr(4'd2, 8'hA5, 1'b0), 17, -1);
    model_write(4'd2, 8'hA5);
    read_check("R10 R5 back-to-back", 4'd2);

    // R9 bad stop and reserved kind
    send(f_wr(4'd2, 8'h3C, 1'b1), 17, -1); settle(); exp_err++;
    check("R9 err counted", err_seen, exp_err);
    read_check("R9 reg kept", 4'd2);
    send(f_bus(3'b110, 2'b11), 7, -1); settle(); exp_err++;
    check("R9 reserved err", err_seen, exp_err);
    check("R9 no breq", breq_valid, 0);

    // R7 sticky interrupts
    cable_pwr_low = 1; loop_timeout = 1;
    @(negedge clk);
    model[6][1:0] = 2'b11;
    send(f_wr(4'd6, 8'h00, 1'b0), 17, -1); settle();
    model[6][7:2] = 6'd0;
    read_check("R7 resets while cause", 4'd6);
    cable_pwr_low = 0; loop_timeout = 0;
    send(f_wr(4'd6, 8'h01, 1'b0), 17, -1); settle();
    model_write(4'd6, 8'h01);
    read_check("R7 clear power keep loop", 4'd6);
    send(f_wr(4'd6, 8'h03, 1'b0), 17, -1); settle();
    model_write(4'd6, 8'h03);
    check("R7 loop still set", model[6][0], 1);
    read_check("R7 write one no effect", 4'd6);

    // R8 short reset trigger
    send(f_wr(4'd9, 8'h85, 1'b0), 17, -1); settle();
    model_write(4'd9, 8'h85);
    check("R8 no pulse when disabled", srst_seen, 0);
    short_mode = 1;
    send(f_wr(4'd9, 8'h80, 1'b0), 17, -1); settle();
    model_write(4'd9, 8'h80);
    check("R8 pulse when enabled", srst_seen, 1);
    send(f_wr(4'd9, 8'h7F, 1'b0), 17, -1); settle();
    model_write(4'd9, 8'h7F);
    check("R8 no pulse bit7 clear", srst_seen, 1);
    read_check("R8 bit7 reads 0", 4'd9);
    short_mode = 0;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [3:0] a;
      logic [7:0] d;
      logic [2:0] k;
      logic [1:0] s;
      op = int'($urandom % 4);
      a  = 4'($urandom);
      d  = 8'($urandom);
      k  = 3'($urandom % 4);
      s  = 2'($urandom);
      if (op == 0) begin
        send(f_bus(k, s), 7, -1); settle();
        check("R3 rand valid", breq_valid, 1);
        check("R3 rand kind", breq_kind, k);
        check("R3 rand speed", breq_speed, s);
        take_breq();
      end else if (op == 1) begin
        read_check("R4 rand read", a);
      end else if (op == 2) begin
        send(f_wr(a, d, 1'b0), 17, -1); settle();
        model_write(a, d);
      end else begin
        if (d[0]) send(f_wr(a, d, 1'b1), 17, -1);
        else      send(f_bus(3'b111, s), 7, -1);
        settle(); exp_err++;
        check("R9 rand err", err_seen, exp_err);
      end
    end
    for (int i = 0; i < 16; i++) read_check("R4 final sweep", 4'(i));
    check("R8 rand no pulse", srst_seen, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule